// File: doc/BRIEF.md
# Byte-Offset Cell Write Aligner

This block writes one 48-byte cell payload into a destination buffer whose start address can sit on any byte boundary. The payload arrives as twelve aligned 32-bit words over a valid/ready stream. The block moves each byte to its correct lane by shifting the stream by the start offset. Bytes that spill past the top of one word are held and merged into the next word. The block then issues word-aligned write beats to the system bus. Each beat carries active-low byte enables and a burst size code.

A transfer begins with a start request that carries the byte start address. An aligned start gives one 12-word burst with every lane written. A misaligned start gives a 12-word burst followed by a 1-word cycle. The first word of that burst writes only the upper lanes. The trailing single word writes only the lanes left over. The bus address always carries 00 in its two low-order bits. Lanes are little-endian: byte address `base + n` sits on lane `n mod 4`.

Top module: `cell_wr_aligner`

## Requirements
- R1: A start request is taken only while `start_ready` is high, which holds exactly while no transfer is in progress. A start request made during a transfer has no effect on the addresses, enables or beat count of that transfer.
- R2: Every write beat drives an address whose two low-order bits are 00. The first beat uses the start address with its low two bits cleared, and each further beat of the transfer adds 4.
- R3: With start offset 0, the transfer is exactly 12 beats. Each beat has `wr_be_n` = 4'b0000 and `wr_size` = 3'b101.
- R4: With start offset k in 1..3, the first beat enables lanes k..3 only: `wr_be_n` is 4'b0001, 4'b0011 or 4'b0111 for k = 1, 2, 3.
- R5: With start offset k in 1..3, a 13th beat follows the 12-word burst. It uses `wr_size` = 3'b000 and address base+48, and enables lanes 0..k-1 only: `wr_be_n` is 4'b1110, 4'b1100 or 4'b1000 for k = 1, 2, 3.
- R6: Payload byte i (byte b of input word w, i = 4w+b) appears on the beat and lane whose byte address is start+i. Beat j, lane l carries payload byte 4j+l-k.
- R7: With start offset k in 1..3, beats 2 through 12 have `wr_be_n` = 4'b0000 and `wr_size` = 3'b101.
- R8: `in_ready` is high only during the burst part of a transfer. Each accepted input word produces exactly one write beat on the following cycle. Input presented while idle produces no beat.
- R9: While reset is asserted, `wr_strobe` and `in_ready` are low and `start_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start request |
| start_addr | input | ADDR_W | Byte start address of destination buffer |
| start_ready | output | 1 | Block idle, start request will be taken |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input payload word, byte 0 in bits 7:0 |
| in_ready | output | 1 | Input word accepted when valid |
| wr_strobe | output | 1 | Write beat valid this cycle |
| wr_addr | output | ADDR_W | Word-aligned write address |
| wr_data | output | 32 | Write data, lane n in bits 8n+7:8n |
| wr_be_n | output | 4 | Active-low byte enables |
| wr_size | output | 3 | Burst size code: 101 for 12-word burst, 000 for single word |

## Verification
The bench runs all four start offsets, with and without input stalls. It compares every lane of every beat against the byte address that lane should hold. A shift in the wrong direction, or a held byte that is dropped, shows up as wrong payload bytes on enabled lanes. A mistake in the lead or tail mask shows up as an enable mismatch on beat 1 or beat 13. Dropping the 1-word tail, or emitting it for an aligned start, changes the beat count. A start request made mid-transfer and input words offered while idle check that neither one disturbs the transfer or creates a stray beat.

// File: rtl/cell_wr_aligner.sv
module cell_wr_aligner #(
  parameter int          ADDR_W      = 32,
  parameter int          CELL_WORDS  = 12,
  parameter logic [2:0]  SIZE_BURST  = 3'b101,
  parameter logic [2:0]  SIZE_SINGLE = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              start_ready,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  output logic              in_ready,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be_n,
  output logic [2:0]        wr_size
);

  localparam int CW = $clog2(CELL_WORDS + 1);
  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_BURST = 2'd1;
  localparam logic [1:0] ST_TAIL  = 2'd2;

  logic [1:0]        st;
  logic [CW-1:0]     beat_cnt;
  logic [1:0]        off;
  logic [ADDR_W-1:0] next_addr;
  logic [31:0]       held;
  logic [63:0]       merged;
  logic [5:0]        sh;
  logic [3:0]        lead_mask;
  logic              fire, first_beat, last_beat;

  assign start_ready = (st == ST_IDLE);
  assign in_ready    = (st == ST_BURST);
  assign fire        = in_valid & in_ready;
  assign sh          = {1'b0, off, 3'b000};
  assign merged      = ({32'b0, in_data} << sh) | {32'b0, held};
  assign lead_mask   = 4'(4'hF << off);
  assign first_beat  = (beat_cnt == '0);
  assign last_beat   = (beat_cnt == CW'(CELL_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      beat_cnt  <= '0;
      off       <= '0;
      next_addr <= '0;
      held      <= '0;
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_be_n   <= 4'hF;
      wr_size   <= SIZE_SINGLE;
    end else begin
      wr_strobe <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_valid) begin
            off       <= start_addr[1:0];
            next_addr <= {start_addr[ADDR_W-1:2], 2'b00};
            beat_cnt  <= '0;
            held      <= '0;
            st        <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (fire) begin
            wr_strobe <= 1'b1;
            wr_addr   <= next_addr;
            wr_data   <= merged[31:0];
            wr_be_n   <= first_beat ? ~lead_mask : 4'h0;
            wr_size   <= SIZE_BURST;
            held      <= merged[63:32];
            next_addr <= next_addr + ADDR_W'(4);
            beat_cnt  <= beat_cnt + 1'b1;
            if (last_beat) st <= (off != 2'b00) ? ST_TAIL : ST_IDLE;
          end
        end
        ST_TAIL: begin
          wr_strobe <= 1'b1;
          wr_addr   <= next_addr;
          wr_data   <= held;
          wr_be_n   <= lead_mask;
          wr_size   <= SIZE_SINGLE;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cell_wr_aligner_chk.sv
module cell_wr_aligner_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_ready,
  input logic              in_valid,
  input logic              in_ready,
  input logic              wr_strobe,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [3:0]        wr_be_n,
  input logic [2:0]        wr_size
);

  AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> wr_addr[1:0] == 2'b00); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe && $past(wr_strobe) |-> wr_addr == $past(wr_addr) + ADDR_W'(4)); // R2

  AST_BEAT_PER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> wr_strobe); // R8

  AST_IDLE_TAKES_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !in_ready); // R8

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (wr_size == 3'b101 || wr_size == 3'b000)); // R3

  AST_TAIL_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe && wr_size == 3'b000 |-> wr_be_n != 4'h0 && wr_be_n != 4'hF); // R5

  AST_TAIL_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe && wr_size == 3'b000 |-> $past(wr_strobe) && $past(wr_size) == 3'b101); // R5

endmodule

bind cell_wr_aligner cell_wr_aligner_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_ready(start_ready), .in_valid(in_valid),
  .in_ready(in_ready), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
  .wr_be_n(wr_be_n), .wr_size(wr_size)
);

// File: tb/cell_wr_aligner_tb.sv
module cell_wr_aligner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic [31:0] start_addr = '0;
  logic        start_ready;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        wr_strobe;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be_n;
  logic [2:0]  wr_size;

  always #2 clk = ~clk;

  cell_wr_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .start_ready(start_ready), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be_n(wr_be_n), .wr_size(wr_size)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int nbeat;
  logic [31:0] cap_addr [16];
  logic [31:0] cap_data [16];
  logic [3:0]  cap_be   [16];
  logic [2:0]  cap_size [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (wr_strobe) begin
      if (nbeat < 16) begin
        cap_addr[nbeat] = wr_addr;
        cap_data[nbeat] = wr_data;
        cap_be[nbeat]   = wr_be_n;
        cap_size[nbeat] = wr_size;
      end
      nbeat++;
    end
  endtask

  task automatic t_reset();
    nbeat = 0;
    repeat (3) step();
    chk(wr_strobe == 1'b0, "R9", "strobe in reset", wr_strobe, 0);
    chk(start_ready == 1'b1, "R9", "start_ready in reset", start_ready, 1);
    chk(in_ready == 1'b0, "R9", "in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_idle_input();
    nbeat = 0;
    in_valid = 1'b1;
    in_data = 32'hDEADBEEF;
    repeat (3) step();
    in_valid = 1'b0;
    step();
    chk(nbeat == 0, "R8", "beats from idle input", nbeat, 0);
    chk(in_ready == 1'b0, "R8", "in_ready while idle", in_ready, 0);
  endtask

  task automatic t_xfer(input int k, input logic [31:0] base, input bit gaps, input bit poke);
    logic [7:0] p [48];
    int w, cyc, exp_n;
    bit rdy;
    for (int i = 0; i < 48; i++) p[i] = 8'(base[11:4] + i * 13 + k);
    chk(start_ready == 1'b1, "R1", "start_ready before start", start_ready, 1);
    nbeat = 0;
    start_valid = 1'b1;
    start_addr = base | 32'(k);
    step();
    start_valid = 1'b0;
    w = 0;
    cyc = 0;
    while (w < 12) begin
      in_valid = !(gaps && (cyc % 3 == 1));
      in_data = {p[4*w+3], p[4*w+2], p[4*w+1], p[4*w]};
      if (poke && w == 3) begin
        start_valid = 1'b1;
        start_addr = 32'h0000_8003;
      end else start_valid = 1'b0;
      rdy = in_ready;
      step();
      if (in_valid && rdy) w++;
      cyc++;
    end
    in_valid = 1'b0;
    start_valid = 1'b0;
    repeat (4) step();
    exp_n = (k != 0) ? 13 : 12;
    chk(nbeat == exp_n, (k != 0) ? "R5" : "R3", "beat count", nbeat, exp_n);
    if (poke) chk(nbeat == exp_n, "R1", "beat count after mid-transfer start", nbeat, exp_n);
    for (int j = 0; j < nbeat && j < 16; j++) begin
      string tag;
      logic [3:0] ebe;
      logic [2:0] esz;
      tag = (k == 0) ? "R3" : (j == 0) ? "R4" : (j == 12) ? "R5" : "R7";
      chk(cap_addr[j] == (base & ~32'h3) + 32'(4 * j), poke ? "R1" : "R2", "beat address",
          cap_addr[j], (base & ~32'h3) + 32'(4 * j));
      esz = (j < 12) ? 3'b101 : 3'b000;
      chk(cap_size[j] == esz, tag, "size code", cap_size[j], esz);
      for (int l = 0; l < 4; l++) begin
        int idx;
        idx = 4 * j + l - k;
        ebe[l] = !(idx >= 0 && idx < 48);
      end
      chk(cap_be[j] == ebe, tag, "byte enables", cap_be[j], ebe);
      for (int l = 0; l < 4; l++) begin
        int idx;
        idx = 4 * j + l - k;
        if (idx >= 0 && idx < 48)
          chk(cap_data[j][8*l +: 8] == p[idx], "R6", "lane byte", cap_data[j][8*l +: 8], p[idx]);
      end
    end
    chk(start_ready == 1'b1, "R1", "idle after transfer", start_ready, 1);
    chk(in_ready == 1'b0, "R8", "in_ready after transfer", in_ready, 0);
  endtask

  initial begin
    t_reset();
    t_idle_input();
    t_xfer(0, 32'h0000_1000, 1'b0, 1'b0);
    t_xfer(1, 32'h0000_2040, 1'b1, 1'b0);
    t_xfer(2, 32'h0000_3100, 1'b0, 1'b0);
    t_xfer(3, 32'h0000_4210, 1'b1, 1'b0);
    t_xfer(2, 32'h0000_5320, 1'b1, 1'b1);
    t_xfer(0, 32'h0000_6430, 1'b1, 1'b1);
    t_idle_input();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule